// File: doc/BRIEF.md
# Per-Line Scroll Offset Store

This block keeps one scroll offset for every 8-pixel band of the screen, so a tile layer can be shifted by a different amount on each band. In row mode each band is a horizontal strip and the stored value takes the place of the global horizontal scroll. In column mode each band is a vertical strip and the stored value, cut to its low 8 bits, takes the place of the global vertical scroll. When the band being drawn is in text mode, both effective offsets are forced to zero.

The processor reaches the store through a byte-wide port. A 9-bit entry occupies two byte locations: one holds the low byte and the other holds the single top bit. The video side gives a band index and receives the effective X and Y offsets combinationally. Storage is a bank of hold-or-load registers, one per entry, rather than a RAM macro.

Top module: `scroll_line_store`

## Requirements
- R1: After reset every entry reads as zero through both byte locations, and the row-mode lookup returns zero.
- R2: A write with `cpu_addr` below 0x2000 and `cpu_addr[6]`=0 loads `cpu_wdata` into bits 7:0 of the entry chosen by `cpu_addr[4:0]`; bit 8 of that entry is unchanged. All other address bits are ignored.
- R3: A write with `cpu_addr` below 0x2000 and `cpu_addr[6]`=1 loads `cpu_wdata[0]` into bit 8 of the chosen entry; bits 7:0 are unchanged.
- R4: A read below 0x2000 is combinational: with `cpu_addr[6]`=0 it returns bits 7:0 of the chosen entry; with `cpu_addr[6]`=1 it returns bit 8 in data bit 0 and zeros in data bits 7:1.
- R5: At addresses 0x2000 and above, `cpu_rdata` is zero and writes change no entry.
- R6: Row mode (`vid_line_en`=1, `vid_col_mode`=0, `vid_text`=0): `eff_x` is the full 9-bit entry at `vid_index`, and `eff_y` equals `glob_y`.
- R7: Column mode (`vid_line_en`=1, `vid_col_mode`=1, `vid_text`=0): `eff_y` is bits 7:0 of the entry at `vid_index` with bit 8 zero, and `eff_x` equals `glob_x`.
- R8: With `vid_line_en`=0 and `vid_text`=0, `eff_x` equals `glob_x` and `eff_y` equals `glob_y`.
- R9: With `vid_text`=1, `eff_x` and `eff_y` are both zero, whatever the other mode inputs.
- R10: A written value reaches the lookup after the next rising clock edge and not earlier.
- R11: In any cycle without an in-window write, every entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_we | input | 1 | Write strobe, sampled on the rising edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data |
| vid_index | input | 5 | Band index for the lookup |
| vid_line_en | input | 1 | 1 = per-band offsets replace the global value |
| vid_col_mode | input | 1 | 0 = row mode (overrides X), 1 = column mode (overrides Y) |
| vid_text | input | 1 | Current band is in text mode |
| glob_x | input | 9 | Global horizontal scroll |
| glob_y | input | 9 | Global vertical scroll |
| eff_x | output | 9 | Effective horizontal scroll |
| eff_y | output | 9 | Effective vertical scroll |

## Verification
The write-then-read properties assume the processor holds a stable address for a cycle after a write when it reads back, and the bench keeps every read-back address equal to the address just written. The checks also assume that `cpu_we` is never X while reset is released. The bench drives all inputs on the falling edge, so the mode inputs and the index never change near the capture edge. The stimulus covers aliasing addresses with don't-care bits set, so the decode is exercised beyond the plain 0..0x5F range.

// File: rtl/scroll_line_pkg.sv
package scroll_line_pkg;

  typedef enum logic [1:0] {
    PICK_GLOBAL = 2'd0,
    PICK_ROW    = 2'd1,
    PICK_COL    = 2'd2,
    PICK_ZERO   = 2'd3
  } pick_t;

  // Which source feeds the effective offsets for the current band
  function automatic pick_t pick_source(input logic text, input logic en,
                                        input logic col);
    if (text)     return PICK_ZERO;
    else if (!en) return PICK_GLOBAL;
    else if (col) return PICK_COL;
    else          return PICK_ROW;
  endfunction

endpackage

// File: rtl/scroll_cpu_port.sv
module scroll_cpu_port #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 32,
  parameter int HI_BIT  = 6,
  parameter logic [ADDR_W-1:0] WINDOW = 16'h2000,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_we,
  output logic               in_window,
  output logic               sel_hi,
  output logic [IDX_W-1:0]   sel_idx,
  output logic [ENTRIES-1:0] wr_lo,
  output logic [ENTRIES-1:0] wr_hi
);

  function automatic logic below_limit(input logic [ADDR_W-1:0] a);
    return a < WINDOW;
  endfunction

  assign in_window = below_limit(cpu_addr);
  assign sel_hi    = cpu_addr[HI_BIT];
  assign sel_idx   = cpu_addr[IDX_W-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
    logic hit;
    assign hit      = cpu_we && in_window && (sel_idx == IDX_W'(g));
    assign wr_lo[g] = hit && !sel_hi;
    assign wr_hi[g] = hit &&  sel_hi;
  end

endmodule

// File: rtl/scroll_entry.sv
module scroll_entry #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W:0]   q
);

  logic [DATA_W-1:0] nxt_lo;
  logic              nxt_hi;

  // Two-way choice per element: new data or the held value
  assign nxt_lo = ld_lo ? din    : q[DATA_W-1:0];
  assign nxt_hi = ld_hi ? din[0] : q[DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {nxt_hi, nxt_lo};
  end

endmodule

// File: rtl/scroll_select.sv
module scroll_select #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W:0] entry,
  input  logic            vid_line_en,
  input  logic            vid_col_mode,
  input  logic            vid_text,
  input  logic [DATA_W:0] glob_x,
  input  logic [DATA_W:0] glob_y,
  output logic [DATA_W:0] eff_x,
  output logic [DATA_W:0] eff_y
);
  import scroll_line_pkg::*;

  pick_t pick;
  assign pick = pick_source(vid_text, vid_line_en, vid_col_mode);

  always_comb begin
    unique case (pick)
      PICK_ZERO: begin eff_x = '0;     eff_y = '0;                         end
      PICK_ROW:  begin eff_x = entry;  eff_y = glob_y;                     end
      PICK_COL:  begin eff_x = glob_x; eff_y = {1'b0, entry[DATA_W-1:0]};  end
      default:   begin eff_x = glob_x; eff_y = glob_y;                     end
    endcase
  end

endmodule

// File: rtl/scroll_line_store.sv
module scroll_line_store #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 32,
  parameter int HI_BIT  = 6,
  parameter logic [ADDR_W-1:0] WINDOW = 16'h2000,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ENT_W  = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [IDX_W-1:0]  vid_index,
  input  logic              vid_line_en,
  input  logic              vid_col_mode,
  input  logic              vid_text,
  input  logic [DATA_W:0]   glob_x,
  input  logic [DATA_W:0]   glob_y,
  output logic [DATA_W:0]   eff_x,
  output logic [DATA_W:0]   eff_y
);

  logic                     in_window;
  logic                     sel_hi;
  logic [IDX_W-1:0]         sel_idx;
  logic [ENTRIES-1:0]       wr_lo;
  logic [ENTRIES-1:0]       wr_hi;
  logic [ENT_W-1:0]         store [ENTRIES];
  logic [ENTRIES*ENT_W-1:0] store_flat;
  logic [ENT_W-1:0]         rd_entry;
  logic [ENT_W-1:0]         vid_entry;

  scroll_cpu_port #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .HI_BIT(HI_BIT), .WINDOW(WINDOW)
  ) u_port (
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .in_window(in_window),
    .sel_hi(sel_hi), .sel_idx(sel_idx), .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    scroll_entry #(.DATA_W(DATA_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .ld_lo(wr_lo[g]), .ld_hi(wr_hi[g]),
      .din(cpu_wdata), .q(store[g])
    );
    assign store_flat[g*ENT_W +: ENT_W] = store[g];
  end

  function automatic logic [DATA_W-1:0] read_byte(input logic ok,
      input logic hi, input logic [ENT_W-1:0] e);
    if (!ok)     return '0;
    else if (hi) return {{(DATA_W-1){1'b0}}, e[DATA_W]};
    else         return e[DATA_W-1:0];
  endfunction

  assign rd_entry  = store[sel_idx];
  assign cpu_rdata = read_byte(in_window, sel_hi, rd_entry);
  assign vid_entry = store[vid_index];

  scroll_select #(.DATA_W(DATA_W)) u_sel (
    .entry(vid_entry), .vid_line_en(vid_line_en), .vid_col_mode(vid_col_mode),
    .vid_text(vid_text), .glob_x(glob_x), .glob_y(glob_y),
    .eff_x(eff_x), .eff_y(eff_y)
  );

endmodule

// File: rtl/scroll_line_store_chk.sv
module scroll_line_store_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 32,
  parameter int HI_BIT  = 6,
  parameter logic [ADDR_W-1:0] WINDOW = 16'h2000,
  localparam int ENT_W  = DATA_W + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        cpu_addr,
  input logic                     cpu_we,
  input logic [DATA_W-1:0]        cpu_wdata,
  input logic [DATA_W-1:0]        cpu_rdata,
  input logic                     vid_line_en,
  input logic                     vid_col_mode,
  input logic                     vid_text,
  input logic [DATA_W:0]          glob_x,
  input logic [DATA_W:0]          glob_y,
  input logic [DATA_W:0]          eff_x,
  input logic [DATA_W:0]          eff_y,
  input logic [ENTRIES-1:0]       wr_lo,
  input logic [ENTRIES-1:0]       wr_hi,
  input logic [ENTRIES*ENT_W-1:0] store_flat
);

  logic in_win;
  assign in_win = cpu_addr < WINDOW;

  // R2
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && in_win && !cpu_addr[HI_BIT]) ##1 (cpu_addr == $past(cpu_addr))
      |-> cpu_rdata == $past(cpu_wdata));

  // R3
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && in_win && cpu_addr[HI_BIT]) ##1 (cpu_addr == $past(cpu_addr))
      |-> cpu_rdata == {{(DATA_W-1){1'b0}}, $past(cpu_wdata[0])});

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi}));

  // R4
  hi_read_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && cpu_addr[HI_BIT]) |-> cpu_rdata[DATA_W-1:1] == '0);

  // R5
  out_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (cpu_rdata == '0 && wr_lo == '0 && wr_hi == '0));

  // R7
  col_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vid_text && vid_line_en && vid_col_mode)
      |-> (eff_y[DATA_W] == 1'b0 && eff_x == glob_x));

  // R8
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vid_text && !vid_line_en) |-> (eff_x == glob_x && eff_y == glob_y));

  // R9
  text_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_text |-> (eff_x == '0 && eff_y == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo == '0 && wr_hi == '0) |=> $stable(store_flat));

endmodule

bind scroll_line_store scroll_line_store_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .HI_BIT(HI_BIT),
  .WINDOW(WINDOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vid_line_en(vid_line_en),
  .vid_col_mode(vid_col_mode), .vid_text(vid_text), .glob_x(glob_x),
  .glob_y(glob_y), .eff_x(eff_x), .eff_y(eff_y), .wr_lo(wr_lo),
  .wr_hi(wr_hi), .store_flat(store_flat)
);

// File: tb/scroll_line_store_tb.sv
`timescale 1ns/1ps
module scroll_line_store_tb;

  localparam logic [8:0] GX = 9'h1A5;
  localparam logic [8:0] GY = 9'h0C3;

  // mode field: {text, line_en, col}
  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [4:0]  idx;
    logic [2:0]  mode;
    logic [7:0]  exp_rd;
    logic [8:0]  exp_x;
    logic [8:0]  exp_y;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0003, 8'h5A, 5'd0,  3'b000, 8'h00, 9'h000, 9'h000, 4'd2},  // R2
    '{1'b1, 16'h0043, 8'h01, 5'd0,  3'b000, 8'h00, 9'h000, 9'h000, 4'd3},  // R3
    '{1'b1, 16'h001F, 8'hC7, 5'd0,  3'b000, 8'h00, 9'h000, 9'h000, 4'd2},
    '{1'b1, 16'h2003, 8'hFF, 5'd0,  3'b000, 8'h00, 9'h000, 9'h000, 4'd5},  // R5
    '{1'b0, 16'h0003, 8'h00, 5'd3,  3'b010, 8'h5A, 9'h15A, GY,     4'd6},  // R6
    '{1'b0, 16'h0043, 8'h00, 5'd3,  3'b011, 8'h01, GX,     9'h05A, 4'd7},  // R7
    '{1'b0, 16'h001F, 8'h00, 5'd31, 3'b010, 8'hC7, 9'h0C7, GY,     4'd4},  // R4
    '{1'b0, 16'h2003, 8'h00, 5'd3,  3'b000, 8'h00, GX,     GY,     4'd8},  // R8
    '{1'b0, 16'h005F, 8'h00, 5'd31, 3'b110, 8'h00, 9'h000, 9'h000, 4'd9},  // R9
    '{1'b1, 16'h0FA3, 8'h33, 5'd0,  3'b000, 8'h00, 9'h000, 9'h000, 4'd2},
    '{1'b0, 16'h0003, 8'h00, 5'd3,  3'b010, 8'h33, 9'h133, GY,     4'd2},
    '{1'b1, 16'h0043, 8'hFE, 5'd0,  3'b000, 8'h00, 9'h000, 9'h000, 4'd3},
    '{1'b0, 16'h0043, 8'h00, 5'd3,  3'b010, 8'h00, 9'h033, GY,     4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [4:0]  vid_index = '0;
  logic        vid_line_en = 1'b0;
  logic        vid_col_mode = 1'b0;
  logic        vid_text = 1'b0;
  logic [8:0]  glob_x = GX;
  logic [8:0]  glob_y = GY;
  logic [8:0]  eff_x;
  logic [8:0]  eff_y;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  scroll_line_store u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vid_index(vid_index),
    .vid_line_en(vid_line_en), .vid_col_mode(vid_col_mode),
    .vid_text(vid_text), .glob_x(glob_x), .glob_y(glob_y),
    .eff_x(eff_x), .eff_y(eff_y)
  );

  task automatic check(input string tag, input logic [8:0] act,
                       input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents, both byte locations and the row lookup
    vid_line_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      cpu_addr = 16'(i); vid_index = 5'(i);
      #1 check("R1 lo", {1'b0, cpu_rdata}, 9'h000);
      check("R1 lookup", eff_x, 9'h000);
      cpu_addr = 16'(i) | 16'h0040;
      #1 check("R1 hi", {1'b0, cpu_rdata}, 9'h000);
    end

    // Vector table
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) begin
        cpu_write(VECS[v].addr, VECS[v].data);
      end else begin
        @(negedge clk);
        cpu_addr = VECS[v].addr; vid_index = VECS[v].idx;
        {vid_text, vid_line_en, vid_col_mode} = VECS[v].mode;
        #1;
        check($sformatf("R%0d vec%0d rdata", VECS[v].req, v),
              {1'b0, cpu_rdata}, {1'b0, VECS[v].exp_rd});
        check($sformatf("R%0d vec%0d eff_x", VECS[v].req, v), eff_x, VECS[v].exp_x);
        check($sformatf("R%0d vec%0d eff_y", VECS[v].req, v), eff_y, VECS[v].exp_y);
      end
    end

    // R10: write is not visible before the edge, visible after it
    @(negedge clk);
    vid_index = 5'd5; {vid_text, vid_line_en, vid_col_mode} = 3'b010;
    cpu_addr = 16'h0005; cpu_wdata = 8'h77; cpu_we = 1'b1;
    #1 check("R10 before edge", eff_x, 9'h000);
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
    #1 check("R10 after edge", eff_x, 9'h077);

    // R11: idle cycles and out-of-window writes leave the entry alone
    repeat (5) @(negedge clk);
    cpu_write(16'h8005, 8'h11);
    cpu_write(16'h2045, 8'h01);
    #1 check("R11 hold", eff_x, 9'h077);

    // R3: high write leaves low byte; R7 drops bit 8 in column mode
    cpu_write(16'h0045, 8'hFF);
    #1 check("R3 hi keeps lo", eff_x, 9'h177);
    vid_col_mode = 1'b1;
    #1 check("R7 col drops bit8", eff_y, 9'h077);
    check("R7 col x global", eff_x, GX);

    // R9: text forces zero in column mode too
    vid_text = 1'b1;
    #1 check("R9 text col", eff_y, 9'h000);
    check("R9 text col x", eff_x, 9'h000);

    // R8: disabled per-band scroll passes globals with new values
    vid_text = 1'b0; vid_line_en = 1'b0; glob_x = 9'h0FE; glob_y = 9'h101;
    #1 check("R8 pass x", eff_x, 9'h0FE);
    check("R8 pass y", eff_y, 9'h101);

    // R1: asynchronous reset clears entries again
    rst_n = 1'b0;
    #2 rst_n = 1'b1;
    cpu_addr = 16'h0005;
    #1 check("R1 re-reset", {1'b0, cpu_rdata}, 9'h000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule